// File: doc/BRIEF.md
# Programmable triangle and rectangle waveform generator

This block produces a 16-bit unsigned code for a DAC. The code moves up from a low limit to a high limit in fixed increments and then moves back down. This repeats for as long as the block runs. Every code is held for a programmable number of clock cycles, so a 32-bit hold count reaches very low output frequencies. When the increment is as large as the whole range, the output jumps straight between the two limits and forms a rectangle. A staircase setting splits the range into five equal levels in each direction.

The host computes all settings from the frequency and amplitude it wants. The block clamps every move at the limits and never wraps, whatever settings it is given. Settings written while a ramp is running take effect only when the output reaches a limit, so a period in progress is never broken. A direction output marks rising and falling halves, which lets a second generator or a capture unit line up with the waveform.

Top module: `tri_wave_gen`

## Requirements
- R1: While reset is high and in the first cycle after it, `wave_code` equals `start_code` and `rising` is 1.
- R2: After each hold period, a rising output grows by the effective step and a falling output shrinks by it. It turns at the high limit and at the low limit, and repeats without end.
- R3: Each output code stays unchanged for `hold_cycles` clock cycles before the next move. A hold count of 0 behaves as 1.
- R4: When the next move would pass the high limit, the output is set to the high limit and the direction becomes falling. When the next move would reach or pass below the low limit, the output is set to the low limit and the direction becomes rising. This holds even when the range is not a multiple of the step.
- R5: When `step_code` is at least `stop_code - start_code`, the output alternates between `start_code` and `stop_code`.
- R6: A `step_code` of 0 behaves as a step of 1.
- R7: With `stair_mode` = 1, `step_code` is ignored. The step becomes s = floor((stop-start)/5) and the high limit becomes start + 5*s, which gives five equal steps each way. If s is 0, the step is 1 and the high limit is `stop_code`.
- R8: Start, stop, step, hold and mode are taken at reset and again each time the output reaches a limit. Changes made in between do not affect the moves that come before the next limit.
- R9: `rising` is 1 while the output moves up and 0 while it moves down. It changes only in the cycle where the output takes a limit value.
- R10: Codes near 65535 never wrap. With start 65530, stop 65535 and step 4, the output visits 65530, 65534, 65535, 65531 and then 65530 again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_code | input | 16 | Low limit of the waveform |
| stop_code | input | 16 | High limit of the waveform |
| step_code | input | 16 | Increment per move (0 acts as 1) |
| hold_cycles | input | 32 | Clock cycles each code is held (0 acts as 1) |
| stair_mode | input | 1 | 1 selects the five-level staircase |
| wave_code | output | 16 | Waveform code for the DAC |
| rising | output | 1 | 1 while moving up, 0 while moving down |

## Verification
On every cycle, the assertions check that the output changes only when a hold period expires. They also check that a rising move never passes the latched high limit and a falling move never drops below the latched low limit, that a rising move grows by at most the latched step, and that the hold counter stays below the hold count. Only the bench's scenarios can show the exact sequence of codes for each setting: the turn value when the range is not a multiple of the step, the rectangle, the staircase levels, the top of the code range, and the delay of a settings change until the next limit. The bench compares each sequence at both the first and the last cycle of every hold period.

// File: rtl/twg_pkg.sv
package twg_pkg;

    localparam int CODE_W = 16;
    localparam int HOLD_W = 32;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [HOLD_W-1:0] hold_t;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } dir_e;

    // Settings in force for the current half period
    typedef struct packed {
        code_t lo;
        code_t hi;
        code_t inc;
        hold_t hold;
    } twg_cfg_t;

    // A zero count or step would stall the generator; treat it as one
    function automatic code_t nonzero_code(input code_t v);
        return (v == '0) ? code_t'(1) : v;
    endfunction

    function automatic hold_t nonzero_hold(input hold_t v);
        return (v == '0) ? hold_t'(1) : v;
    endfunction

endpackage

// File: rtl/twg_cfg_latch.sv
module twg_cfg_latch
    import twg_pkg::*;
#(
    parameter int STAIR_LEVELS = 5
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     reload,
    input  code_t    start_code,
    input  code_t    stop_code,
    input  code_t    step_code,
    input  hold_t    hold_cycles,
    input  logic     stair_mode,
    output twg_cfg_t act
);

    code_t    span;
    code_t    stair_inc;
    code_t    stair_hi;
    twg_cfg_t nxt;

    // Span is zero when the limits are equal or reversed
    always_comb begin
        span = (stop_code > start_code) ? code_t'(stop_code - start_code) : '0;
    end

    generate
        if (STAIR_LEVELS > 1) begin : g_stair
            code_t slice;
            always_comb begin
                slice = span / code_t'(STAIR_LEVELS);
                if (slice == '0) begin
                    stair_inc = code_t'(1);
                    stair_hi  = stop_code;
                end else begin
                    stair_inc = slice;
                    stair_hi  = code_t'(start_code + code_t'(slice * code_t'(STAIR_LEVELS)));
                end
            end
        end else begin : g_nostair
            always_comb begin
                stair_inc = nonzero_code(step_code);
                stair_hi  = stop_code;
            end
        end
    endgenerate

    always_comb begin
        nxt.lo   = start_code;
        nxt.hold = hold_cycles;
        if (stair_mode) begin
            nxt.inc = stair_inc;
            nxt.hi  = stair_hi;
        end else begin
            nxt.inc = nonzero_code(step_code);
            nxt.hi  = stop_code;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || reload) begin
            act <= nxt;
        end
    end

    // R6
    inc_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        act.inc != '0);

endmodule

// File: rtl/twg_hold_timer.sv
module twg_hold_timer
    import twg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  hold_t hold,
    output logic  adv
);

    hold_t cnt;
    hold_t hold_eff;

    always_comb begin
        hold_eff = nonzero_hold(hold);
        adv      = (cnt >= hold_t'(hold_eff - hold_t'(1)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (adv) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + hold_t'(1);
        end
    end

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt < hold_eff);

endmodule

// File: rtl/twg_ramp_core.sv
module twg_ramp_core
    import twg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  adv,
    input  code_t rst_val,
    input  code_t lo,
    input  code_t hi,
    input  code_t inc,
    output code_t val,
    output dir_e  dir,
    output logic  turn
);

    logic [CODE_W:0] up_sum;
    logic [CODE_W:0] lo_plus;
    logic            up_hit;
    logic            dn_hit;
    code_t           nxt_val;
    dir_e            nxt_dir;

    // Compare in one extra bit so nothing wraps near the top code
    always_comb begin
        up_sum  = {1'b0, val} + {1'b0, inc};
        lo_plus = {1'b0, lo}  + {1'b0, inc};
        up_hit  = (up_sum >= {1'b0, hi});
        dn_hit  = ({1'b0, val} <= lo_plus);
        if (dir == DIR_UP) begin
            nxt_val = up_hit ? hi : up_sum[CODE_W-1:0];
            nxt_dir = up_hit ? DIR_DOWN : DIR_UP;
        end else begin
            nxt_val = dn_hit ? lo : code_t'(val - inc);
            nxt_dir = dn_hit ? DIR_UP : DIR_DOWN;
        end
        turn = adv && ((dir == DIR_UP) ? up_hit : dn_hit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            val <= rst_val;
            dir <= DIR_UP;
        end else if (adv) begin
            val <= nxt_val;
            dir <= nxt_dir;
        end
    end

    // R3
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !adv |=> ($stable(val) && $stable(dir)));

    // R4
    hi_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && dir == DIR_UP) |=> val <= $past(hi));

    // R4
    lo_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && dir == DIR_DOWN) |=> val >= $past(lo));

    // R2
    step_size_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && dir == DIR_UP && val < hi) |=>
            (val > $past(val)) && (code_t'(val - $past(val)) <= $past(inc)));

    // R9
    dir_flip_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && dir == DIR_UP) |=> (dir == DIR_UP) || (val == $past(hi)));

endmodule

// File: rtl/tri_wave_gen.sv
module tri_wave_gen
    import twg_pkg::*;
#(
    parameter int STAIR_LEVELS = 5
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] start_code,
    input  logic [15:0] stop_code,
    input  logic [15:0] step_code,
    input  logic [31:0] hold_cycles,
    input  logic        stair_mode,
    output logic [15:0] wave_code,
    output logic        rising
);

    twg_cfg_t act;
    logic     adv;
    logic     turn;
    code_t    val;
    dir_e     dir;

    twg_cfg_latch #(
        .STAIR_LEVELS (STAIR_LEVELS)
    ) u_cfg (
        .clk         (clk),
        .rst         (rst),
        .reload      (turn),
        .start_code  (start_code),
        .stop_code   (stop_code),
        .step_code   (step_code),
        .hold_cycles (hold_cycles),
        .stair_mode  (stair_mode),
        .act         (act)
    );

    twg_hold_timer u_timer (
        .clk  (clk),
        .rst  (rst),
        .hold (act.hold),
        .adv  (adv)
    );

    twg_ramp_core u_core (
        .clk     (clk),
        .rst     (rst),
        .adv     (adv),
        .rst_val (start_code),
        .lo      (act.lo),
        .hi      (act.hi),
        .inc     (act.inc),
        .val     (val),
        .dir     (dir),
        .turn    (turn)
    );

    assign wave_code = val;
    assign rising    = (dir == DIR_UP);

endmodule

// File: tb/sim_tri_wave_gen.sv
`timescale 1ns/1ps
module sim_tri_wave_gen;

    localparam int NV = 9;
    localparam int NL = 8;

    // start, stop, step, hold, stair, then eight successive levels
    localparam logic [15:0] V_START [NV] = '{100, 0, 1000, 5, 0, 10, 0, 500, 65530};
    localparam logic [15:0] V_STOP  [NV] = '{130, 25, 2000, 8, 53, 13, 2, 500, 65535};
    localparam logic [15:0] V_STEP  [NV] = '{10, 10, 5000, 0, 7, 9, 1, 3, 4};
    localparam logic [31:0] V_HOLD  [NV] = '{3, 2, 4, 1, 2, 1, 0, 2, 1};
    localparam logic        V_STAIR [NV] = '{0, 0, 0, 0, 1, 1, 0, 0, 0};
    localparam string       V_REQ   [NV] = '{"R2", "R4", "R5", "R6", "R7", "R7", "R3", "R4", "R10"};
    localparam int V_EXP [NV][NL] = '{
        '{100, 110, 120, 130, 120, 110, 100, 110},
        '{0, 10, 20, 25, 15, 5, 0, 10},
        '{1000, 2000, 1000, 2000, 1000, 2000, 1000, 2000},
        '{5, 6, 7, 8, 7, 6, 5, 6},
        '{0, 10, 20, 30, 40, 50, 40, 30},
        '{10, 11, 12, 13, 12, 11, 10, 11},
        '{0, 1, 2, 1, 0, 1, 2, 1},
        '{500, 500, 500, 500, 500, 500, 500, 500},
        '{65530, 65534, 65535, 65531, 65530, 65534, 65535, 65531}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] start_code = '0;
    logic [15:0] stop_code = '0;
    logic [15:0] step_code = '0;
    logic [31:0] hold_cycles = '0;
    logic        stair_mode = 1'b0;
    logic [15:0] wave_code;
    logic        rising;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tri_wave_gen u0 (
        .clk         (clk),
        .rst         (rst),
        .start_code  (start_code),
        .stop_code   (stop_code),
        .step_code   (step_code),
        .hold_cycles (hold_cycles),
        .stair_mode  (stair_mode),
        .wave_code   (wave_code),
        .rising      (rising)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Leaves the bench at a falling edge right after the last reset edge
    task automatic restart(input logic [15:0] s, input logic [15:0] e,
                           input logic [15:0] d, input logic [31:0] h,
                           input logic m);
        @(negedge clk);
        rst = 1'b1;
        start_code = s;
        stop_code = e;
        step_code = d;
        hold_cycles = h;
        stair_mode = m;
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        // Table walk: each level is checked on the first and last cycle of its hold
        for (int v = 0; v < NV; v++) begin
            int h;
            h = (V_HOLD[v] == 0) ? 1 : int'(V_HOLD[v]);
            restart(V_START[v], V_STOP[v], V_STEP[v], V_HOLD[v], V_STAIR[v]);
            for (int i = 0; i < NL; i++) begin
                chk(V_REQ[v], int'(wave_code), V_EXP[v][i]);
                if (h > 1) begin
                    edges(h - 1);
                    chk("R3", int'(wave_code), V_EXP[v][i]);
                end
                edges(1);
            end
        end

        // R1: reset state
        restart(16'd700, 16'd900, 16'd50, 32'd5, 1'b0);
        chk("R1", int'(wave_code), 700);
        chk("R1", int'(rising), 1);

        // R9: direction turns at the top limit only
        restart(16'd100, 16'd130, 16'd10, 32'd1, 1'b0);
        edges(2);
        chk("R9", int'(rising), 1);
        edges(1);
        chk("R9", int'(wave_code), 130);
        chk("R9", int'(rising), 0);
        edges(3);
        chk("R9", int'(wave_code), 100);
        chk("R9", int'(rising), 1);

        // R8: changes mid-ramp wait for the next limit
        restart(16'd0, 16'd100, 16'd10, 32'd1, 1'b0);
        edges(3);
        chk("R8", int'(wave_code), 30);
        stop_code = 16'd200;
        step_code = 16'd1;
        edges(1);
        chk("R8", int'(wave_code), 40);
        edges(6);
        chk("R8", int'(wave_code), 100);
        edges(1);
        chk("R8", int'(wave_code), 99);
        chk("R8", int'(rising), 0);

        // R7: step input has no effect in staircase mode
        restart(16'd0, 16'd53, 16'd1, 32'd1, 1'b1);
        edges(1);
        chk("R7", int'(wave_code), 10);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule